// File: doc/BRIEF.md
# Single-Window Pixel Read Cache

This block sits between a pixel access port and a byte-addressed backing memory. It keeps one aligned window of the surface, 4096 bytes by default, in local storage. A read that falls inside the held window is answered from that storage. A read outside it, or any read while no window is held, first loads the entire window from memory in 32-bit beats and then answers. Writes are never merged into the window. Each write goes straight to memory with a byte-enable mask, and it drops the window so that the next read fetches fresh data.

Requests may be one byte, two bytes or four bytes wide, little-endian and naturally aligned. A fourth mode serves 24-bit colour stored in 32-bit pixels. On a read it returns the word with its top byte forced to 0xFF. On a write it touches only the three low bytes. A separate invalidate input drops the window without any memory traffic. Only one request is in flight at a time.

Top module: `span_window_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `mem_rd_req` and `mem_wr_en` are 0, and no window is held, so the first read always refills.
- R2: An aligned read whose address with the low 12 bits cleared equals the held window base is accepted and answered in the next cycle with `rsp_valid`=1, and it raises no `mem_rd_req`.
- R3: A read that misses raises `mem_rd_req` for one cycle, in the cycle after acceptance, with `mem_rd_addr` = request address with the low 12 bits cleared. The block then stores 1024 beats (`mem_rd_valid` may drop between beats), keeps `req_ready` at 0, and raises `rsp_valid` two cycles after the last beat is taken.
- R4: Read data is little-endian. `req_size`=0 (byte) returns the byte at the address in bits 7:0. `req_size`=1 (half) returns bytes A+1:A in bits 15:0. `req_size`=2 (word) returns bytes A+3..A. Unused upper bits are 0.
- R5: `req_size`=3 (colour) reads return bytes A+2..A in bits 23:0, with bits 31:24 set to 0xFF.
- R6: An accepted write drives `mem_wr_en` and `rsp_valid` for one cycle, in the cycle after acceptance. `mem_wr_addr` is the byte address divided by 4. `mem_wr_be` is 0001<<(A mod 4) for a byte write, 0011<<(A mod 4) for a half write, 1111 for a word write and 0111 for a colour write. Data sits in the enabled byte lanes.
- R7: Every accepted write, of any size, drops the window. The next read, even one inside the same window, refills and returns the written data.
- R8: A one-cycle pulse on `inval` drops the window and causes no memory read or write.
- R9: A half request with address bit 0 set, or a word or colour request with address bits 1:0 not 00, is answered in the next cycle with `rsp_err`=1. It causes no memory access and leaves the held window unchanged.
- R10: `rsp_valid` lasts exactly one cycle per accepted request. No new request is accepted between a miss and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 colour (24 of 32 bits) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, value in the low bits |
| inval | input | 1 | Drop the held window |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Request was misaligned and not serviced |
| rsp_rdata | output | 32 | Read data |
| mem_rd_req | output | 1 | Start a window refill burst |
| mem_rd_addr | output | ADDR_W | Byte address of the window to fetch |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | 32 | Refill beat, lowest address first |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W-2 | Word address of the write |
| mem_wr_data | output | 32 | Write data placed in byte lanes |
| mem_wr_be | output | 4 | Byte enables of the write |

## Verification
A stale window base or a valid flag that fails to drop shows up within one response. A read after a write or after `inval` returns the old bytes with no preceding `mem_rd_req`, so the missing refill is visible on the cycle after acceptance. A fill counter that is off by one stores beats at shifted word slots. The next read then returns a neighbour's data. A wrong lane shift or mask is caught at once on `rsp_rdata` or `mem_wr_be`/`mem_wr_data` in the single response cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RGBX = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_LOOK = 2'd2
    } ctl_state_e;

    typedef struct packed {
        acc_size_e  size;
        logic [1:0] lane;
    } acc_shape_t;

    function automatic logic misaligned(acc_size_e s, logic [1:0] lane);
        case (s)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lane[0];
            default: return lane != 2'b00;
        endcase
    endfunction

    function automatic logic [31:0] pick_read(acc_shape_t sh, logic [31:0] w);
        logic [31:0] shifted;
        shifted = w >> {sh.lane, 3'b000};
        case (sh.size)
            SZ_BYTE: return {24'h0, shifted[7:0]};
            SZ_HALF: return {16'h0, shifted[15:0]};
            SZ_WORD: return w;
            default: return {8'hFF, w[23:0]};
        endcase
    endfunction

    function automatic logic [3:0] wr_mask(acc_shape_t sh);
        case (sh.size)
            SZ_BYTE: return 4'b0001 << sh.lane;
            SZ_HALF: return 4'b0011 << sh.lane;
            SZ_WORD: return 4'b1111;
            default: return 4'b0111;
        endcase
    endfunction

    function automatic logic [31:0] wr_lanes(acc_size_e s, logic [31:0] d);
        case (s)
            SZ_BYTE: return {4{d[7:0]}};
            SZ_HALF: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/swc_tag.sv
module swc_tag #(
    parameter int BASE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic [BASE_W-1:0] probe,
    output logic              hit,
    output logic              valid
);
    logic [BASE_W-1:0] base_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            base_q  <= '0;
        end else begin
            if (load) base_q <= probe;
            if (clr)       valid_q <= 1'b0;
            else if (load) valid_q <= 1'b1;
        end
    end

    assign hit   = valid_q && (base_q == probe);
    assign valid = valid_q;
endmodule

// File: rtl/swc_store.sv
module swc_store #(
    parameter int WORDS = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
        if (re) rdata <= cells[ridx];
    end
endmodule

// File: rtl/swc_fill_seq.sv
module swc_fill_seq #(
    parameter int WORDS = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             beat,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) cnt_q <= '0;
        else if (beat)    cnt_q <= cnt_q + 1'b1;
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/span_window_cache.sv
module span_window_cache
    import swc_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int WIN_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              inval,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-3:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [3:0]        mem_wr_be
);
    localparam int OFF_W  = $clog2(WIN_BYTES);
    localparam int IDX_W  = OFF_W - 2;
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int WORDS  = WIN_BYTES / 4;

    ctl_state_e       state_q;
    acc_shape_t       req_shape, cur_shape_q;
    logic [IDX_W-1:0] cur_idx_q, rd_idx, fill_idx;
    logic             accept, req_bad, rd_acc;
    logic             win_hit, win_valid, win_clr, win_load;
    logic             fill_busy, fill_last, beat, rd_en;
    logic             rsp_rd_q;
    logic [31:0]      store_q;

    assign req_shape = '{size: acc_size_e'(req_size), lane: req_addr[1:0]};
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign req_bad   = misaligned(req_shape.size, req_shape.lane);
    assign rd_acc    = accept && !req_write && !req_bad;
    assign win_load  = rd_acc && !win_hit;
    assign win_clr   = inval || (accept && req_write && !req_bad);
    assign fill_busy = (state_q == ST_FILL);
    assign beat      = fill_busy && mem_rd_valid;
    assign rd_en     = (rd_acc && win_hit) || (state_q == ST_LOOK);
    assign rd_idx    = (state_q == ST_LOOK) ? cur_idx_q : req_addr[OFF_W-1:2];

    swc_tag #(.BASE_W(BASE_W)) u_tag (
        .clk   (clk),
        .rst   (rst),
        .clr   (win_clr),
        .load  (win_load),
        .probe (req_addr[ADDR_W-1:OFF_W]),
        .hit   (win_hit),
        .valid (win_valid)
    );

    swc_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (beat),
        .widx  (fill_idx),
        .wdata (mem_rd_data),
        .re    (rd_en),
        .ridx  (rd_idx),
        .rdata (store_q)
    );

    swc_fill_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .start (win_load),
        .beat  (beat),
        .idx   (fill_idx),
        .last  (fill_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_shape_q <= '{size: SZ_BYTE, lane: 2'b00};
            cur_idx_q   <= '0;
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_rd_q    <= 1'b0;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            mem_wr_be   <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            mem_rd_req <= 1'b0;
            mem_wr_en  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_shape_q <= req_shape;
                        cur_idx_q   <= req_addr[OFF_W-1:2];
                        if (req_bad) begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_rd_q  <= 1'b0;
                        end else if (req_write) begin
                            mem_wr_en   <= 1'b1;
                            mem_wr_addr <= req_addr[ADDR_W-1:2];
                            mem_wr_data <= wr_lanes(req_shape.size, req_wdata);
                            mem_wr_be   <= wr_mask(req_shape);
                            rsp_valid   <= 1'b1;
                            rsp_rd_q    <= 1'b0;
                        end else if (win_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rd_q  <= 1'b1;
                        end else begin
                            state_q     <= ST_FILL;
                            mem_rd_req  <= 1'b1;
                            mem_rd_addr <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                        end
                    end
                end
                ST_FILL: begin
                    if (beat && fill_last) state_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    rsp_valid <= 1'b1;
                    rsp_rd_q  <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_rdata = rsp_rd_q ? pick_read(cur_shape_q, store_q) : 32'h0;

endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              inval,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_rd_req,
    input logic              mem_wr_en,
    input logic [3:0]        mem_wr_be,
    input logic              tag_valid,
    input logic              tag_hit,
    input logic              filling
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && tag_hit && req_addr[1:0] == 2'b00)
            |=> (rsp_valid && !rsp_err && !mem_rd_req));

    a_r3_ready_low_after_burst: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !req_ready);

    a_r3_burst_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

    a_r3_no_rsp_in_fill: assert property (@(posedge clk) disable iff (rst)
        filling |-> !rsp_valid);

    a_r6_write_rsp: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (rsp_valid && !rsp_err && mem_wr_be != 4'b0000));

    a_r7_write_drops: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && !mem_rd_req && $countones(req_addr[1:0]) == 0)
            |=> !tag_valid);

    a_r8_inval_drops: assert property (@(posedge clk) disable iff (rst)
        inval |=> !tag_valid);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && !mem_wr_en && !mem_rd_req));

    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind span_window_cache swc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .inval     (inval),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .mem_rd_req(mem_rd_req),
    .mem_wr_en (mem_wr_en),
    .mem_wr_be (mem_wr_be),
    .tag_valid (win_valid),
    .tag_hit   (win_hit),
    .filling   (fill_busy)
);

// File: tb/tb_span_window_cache.sv
module tb_span_window_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 14;
    localparam int WIN        = 4096;
    localparam int BEATS      = WIN / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              inval = 1'b0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [31:0]       mem_rd_data = '0;
    logic              mem_wr_en;
    logic [ADDR_W-3:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic [3:0]        mem_wr_be;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural memory: a fixed pattern overlaid by written bytes
    logic [7:0] wmem [int];
    // behavioural window state
    bit m_valid = 1'b0;
    int m_base  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    span_window_cache #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .inval(inval),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    function automatic logic [7:0] mbyte(int a);
        if (wmem.exists(a)) return wmem[a];
        return 8'((a * 13) ^ (a >> 5));
    endfunction

    function automatic logic [31:0] mword(int a);
        return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory responder: burst of beats with periodic gaps
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                int b;
                b = int'(mem_rd_addr);
                for (int i = 0; i < BEATS; i++) begin
                    @(negedge clk);
                    if (i % 7 == 3) begin
                        mem_rd_valid = 1'b0;
                        @(negedge clk);
                    end
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mword(b + 4 * i);
                end
                @(negedge clk);
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic quiet(string rq);
        @(negedge clk);
        chk(!rsp_valid && !mem_rd_req && !mem_wr_en, rq, "idle outputs",
            {29'b0, rsp_valid, mem_rd_req, mem_wr_en}, 32'h0);
    endtask

    task automatic do_req(bit wr, int sz, int a, logic [31:0] d, string rq);
        bit bad, miss;
        int base, lane;
        logic [31:0] exp;
        logic [3:0] be;
        base = a & ~(WIN - 1);
        lane = a % 4;
        bad  = (sz == 1 && (a % 2) != 0) || (sz >= 2 && lane != 0);
        miss = !wr && !bad && (!m_valid || m_base != base);
        @(negedge clk);
        chk(req_ready, "R10", "ready before request", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
        req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (miss) begin
            int n;
            chk(mem_rd_req, "R3", "refill request", {31'b0, mem_rd_req}, 32'h1);
            chk(int'(mem_rd_addr) == base, "R3", "refill base", 32'(mem_rd_addr), 32'(base));
            m_valid = 1'b1; m_base = base;
            n = 0;
            while (!rsp_valid && n < 3000) begin
                chk(!req_ready && !mem_wr_en, "R3", "ready low during refill",
                    {30'b0, req_ready, mem_wr_en}, 32'h0);
                @(negedge clk);
                n++;
            end
            chk(n > BEATS, "R3", "refill length", 32'(n), 32'(BEATS));
        end else begin
            chk(!mem_rd_req, rq, "no refill", {31'b0, mem_rd_req}, 32'h0);
        end
        chk(rsp_valid, rq, "response valid", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_err == bad, "R9", "error flag", {31'b0, rsp_err}, {31'b0, bad});
        if (bad) begin
            chk(!mem_wr_en, "R9", "no write on error", {31'b0, mem_wr_en}, 32'h0);
        end else if (!wr) begin
            case (sz)
                0: exp = {24'h0, mbyte(a)};
                1: exp = {16'h0, mbyte(a + 1), mbyte(a)};
                2: exp = mword(a);
                default: exp = {8'hFF, mbyte(a + 2), mbyte(a + 1), mbyte(a)};
            endcase
            chk(rsp_rdata == exp, rq, "read data", rsp_rdata, exp);
        end else begin
            case (sz)
                0: be = 4'b0001 << lane;
                1: be = 4'b0011 << lane;
                2: be = 4'b1111;
                default: be = 4'b0111;
            endcase
            chk(mem_wr_en, "R6", "write strobe", {31'b0, mem_wr_en}, 32'h1);
            chk(int'(mem_wr_addr) == a / 4, "R6", "write word address",
                32'(mem_wr_addr), 32'(a / 4));
            chk(mem_wr_be == be, "R6", "byte enables", {28'b0, mem_wr_be}, {28'b0, be});
            for (int k = 0; k < 4; k++) begin
                if (be[k]) begin
                    logic [7:0] eb;
                    eb = (sz < 2) ? d[8*(k-lane) +: 8] : d[8*k +: 8];
                    chk(mem_wr_data[8*k +: 8] == eb, "R6", "lane data",
                        {24'h0, mem_wr_data[8*k +: 8]}, {24'h0, eb});
                    wmem[(a & ~3) + k] = eb;
                end
            end
            m_valid = 1'b0;
        end
        quiet("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready && !rsp_valid && !mem_rd_req && !mem_wr_en, "R1", "reset outputs",
            {28'b0, req_ready, rsp_valid, mem_rd_req, mem_wr_en}, 32'h8);
        do_req(0, 2, 'h0010, 0, "R1");            // first read refills
        do_req(0, 0, 'h0013, 0, "R4");            // byte hit
        do_req(0, 1, 'h0016, 0, "R4");            // half hit
        do_req(0, 2, 'h0FFC, 0, "R2");            // last word of window
        do_req(0, 3, 'h0020, 0, "R5");            // colour read
        do_req(0, 2, 'h1004, 0, "R3");            // new window
        do_req(0, 2, 'h1008, 0, "R2");
        do_req(1, 0, 'h1009, 32'h0000_00AB, "R6");
        do_req(0, 2, 'h1008, 0, "R7");            // refill shows written byte
        do_req(1, 1, 'h2002, 32'h0000_BEEF, "R6");
        do_req(1, 2, 'h2004, 32'hCAFE_F00D, "R6");
        do_req(1, 3, 'h2008, 32'h1122_3344, "R6"); // top byte kept
        do_req(0, 2, 'h2008, 0, "R7");
        do_req(0, 1, 'h2002, 0, "R7");
        do_req(0, 2, 'h2004, 0, "R2");
        // R8 invalidate pulse
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        chk(!mem_rd_req && !mem_wr_en, "R8", "no memory traffic on inval",
            {30'b0, mem_rd_req, mem_wr_en}, 32'h0);
        m_valid = 1'b0;
        quiet("R8");
        do_req(0, 2, 'h2004, 0, "R8");            // refills after inval
        // R9 misaligned requests
        do_req(0, 1, 'h2005, 0, "R9");
        do_req(1, 2, 'h2006, 32'h5555_5555, "R9");
        do_req(0, 3, 'h2001, 0, "R9");
        do_req(0, 2, 'h2000, 0, "R9");            // window still held
        do_req(0, 0, 'h3FFF, 0, "R4");            // top byte of memory
        do_req(0, 3, 'h3FF0, 0, "R5");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule